// File: doc/BRIEF.md
# Service-Request Mailbox Register Interface

This block sits between a host processor and a system controller. The host reaches it over a simple 32-bit register bus. It places a payload in a word-addressed mailbox, then starts a service with one control-register write. That write carries a 16-bit command made of a 7-bit opcode and a mailbox offset. The block checks that it may accept the request. If so, it raises a request toward the controller and holds the command steady. It then waits for a one-cycle done pulse, which carries a 16-bit completion status.

The controller can write response words straight into the mailbox through its own write port. The host reads them back once busy has dropped. If the request asked for notification, completion sets an interrupt-pending bit. That bit drives the interrupt output until the host writes zero to the interrupt register.

Each request attempt leaves an 8-bit issue result in the status register. The result tells the host whether the attempt was accepted, refused because the block was busy, or refused because its offset lay outside the mailbox.

Top module: `svc_mailbox`

## Requirements
- R1: After reset, every register reads zero, `irq` is 0 and `ctl_req` is 0.
- R2: A host write at byte address 0x800+4*i updates only the bytes of mailbox word i whose strobe is set (strobe b covers bits 8b+7:8b), and a read at that address returns the word in the next cycle.
- R3: A control write (0x050) with bit 0 (request) set, bit 2 (abort) clear, busy clear and offset in range is accepted. In the next cycle `ctl_req` is 1 and `ctl_cmd` equals write bits 31:16. The status register (0x054) shows bit 0 = 1, bit 1 (busy) = 1, bit 3 = the write's notify bit 3, and an issue result of 0x00 in bits 15:8.
- R4: A control write with request set while busy is ignored: `ctl_cmd` and the mailbox do not change, and the issue result becomes 0xEF.
- R5: The command's mailbox offset sits in command bits 15:7 and the opcode in bits 6:0. A request whose offset is not below the mailbox depth is not started, and the issue result becomes 0xFF.
- R6: A `ctl_done` pulse while busy clears busy and `ctl_req` in the next cycle and latches `ctl_status` into status bits 31:16.
- R7: Completion of a request that had notify set sets `irq`. Completion of a request without notify leaves `irq` at 0.
- R8: Writing zero to the interrupt register (0x060) clears `irq`, a nonzero write there has no effect, and a completion in the same cycle as a clearing write leaves `irq` set.
- R9: When `ctl_wen` is high, the controller writes a full word into mailbox word `ctl_widx`, which the host can then read.
- R10: A control write with abort (bit 2) set while busy clears busy and `ctl_req` without raising `irq` or changing the status code, and an abort write never starts a request.
- R11: A `ctl_done` pulse while idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Host byte address |
| bus_wen | input | 1 | Host write enable |
| bus_be | input | 4 | Host byte strobes (mailbox writes) |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for `bus_addr` |
| irq | output | 1 | Completion interrupt (pending bit) |
| ctl_req | output | 1 | Request to controller, held while busy |
| ctl_cmd | output | 16 | Command word of the active request |
| ctl_done | input | 1 | One-cycle completion pulse |
| ctl_status | input | 16 | Completion status, sampled with `ctl_done` |
| ctl_wen | input | 1 | Controller mailbox write enable |
| ctl_widx | input | 6 | Controller mailbox word index |
| ctl_wdata | input | 32 | Controller mailbox write data |

## Verification
Two pairs of events can land in the same cycle. In the first, a completion pulse arrives together with the host's clearing write to the interrupt register. The bench drives both at one falling edge and expects `irq` still set afterwards, because setting outranks clearing. In the second, a completion pulse arrives together with a fresh request write. Busy is still set at that edge, so the request must come back refused with 0xEF, and `ctl_req` must be low one cycle later.

// File: rtl/svc_mbox_pkg.sv
package svc_mbox_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int CMD_W    = 16;
    localparam int OPC_W    = 7;
    localparam int OFS_W    = CMD_W - OPC_W;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 12'h050;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 12'h054;
    localparam logic [ADDR_W-1:0] PEND_ADDR = 12'h060;

    localparam int BIT_REQ    = 0;
    localparam int BIT_BUSY   = 1;
    localparam int BIT_ABORT  = 2;
    localparam int BIT_NOTIFY = 3;
    localparam int FIELD_LSB  = 16;

    localparam logic [7:0] RES_OK    = 8'h00;
    localparam logic [7:0] RES_BUSY  = 8'hEF;
    localparam logic [7:0] RES_PARAM = 8'hFF;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_PEND,
        SEL_MBOX
    } reg_sel_e;

    typedef struct packed {
        logic [OFS_W-1:0] offset;
        logic [OPC_W-1:0] opcode;
    } svc_cmd_t;

    typedef struct packed {
        logic        req;
        logic        abort;
        logic        notify;
        svc_cmd_t    cmd;
    } ctrl_write_t;

    function automatic ctrl_write_t split_ctrl(input logic [DATA_W-1:0] w);
        ctrl_write_t r;
        r.req    = w[BIT_REQ];
        r.abort  = w[BIT_ABORT];
        r.notify = w[BIT_NOTIFY];
        r.cmd    = svc_cmd_t'(w[FIELD_LSB +: CMD_W]);
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] strobe_mask(input logic [DATA_W/8-1:0] be);
        logic [DATA_W-1:0] m;
        for (int b = 0; b < DATA_W/8; b++) begin
            m[8*b +: 8] = {8{be[b]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/svc_mbox_decode.sv
module svc_mbox_decode
    import svc_mbox_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDXW-1:0]   idx,
    output logic              idx_ok
);

    localparam int WIN_BIT = ADDR_W - 1;

    always_comb begin
        idx    = addr[IDXW+1:2];
        idx_ok = 1'b0;
        sel    = SEL_NONE;
        if (addr[WIN_BIT]) begin
            sel    = SEL_MBOX;
            idx_ok = ({1'b0, addr[WIN_BIT-1:2]} < (WIN_BIT-1)'(DEPTH));
        end else if (addr == CTRL_ADDR) begin
            sel = SEL_CTRL;
        end else if (addr == STAT_ADDR) begin
            sel = SEL_STAT;
        end else if (addr == PEND_ADDR) begin
            sel = SEL_PEND;
        end
    end

endmodule

// File: rtl/svc_mbox_ram.sv
module svc_mbox_ram
    import svc_mbox_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDXW = $clog2(DEPTH),
    localparam int BEW  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_we,
    input  logic [BEW-1:0]    h_be,
    input  logic [IDXW-1:0]   h_idx,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic              c_we,
    input  logic [IDXW-1:0]   c_idx,
    input  logic [DATA_W-1:0] c_wdata,
    input  logic [IDXW-1:0]   r_idx,
    output logic [DATA_W-1:0] r_data
);

    logic [DATA_W-1:0] h_mask;
    logic [DATA_W-1:0] rd_arr [DEPTH];

    assign h_mask = strobe_mask(h_be);

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (c_we && c_idx == IDXW'(w)) begin
                word_q <= c_wdata;
            end else if (h_we && h_idx == IDXW'(w)) begin
                word_q <= (word_q & ~h_mask) | (h_wdata & h_mask);
            end
        end
        assign rd_arr[w] = word_q;
    end

    assign r_data = rd_arr[r_idx];

    // R2: a host write with no strobe set leaves the addressed word untouched
    a_r2_no_strobe_no_change: assert property (@(posedge clk) disable iff (rst)
        (h_we && h_be == '0 && !c_we && r_idx == h_idx) |=> $stable(r_data) || r_idx != $past(r_idx));

    // R9: a controller write lands whole
    a_r9_ctl_write: assert property (@(posedge clk) disable iff (rst)
        (c_we && r_idx == c_idx) ##1 (r_idx == $past(r_idx)) |-> r_data == $past(c_wdata));

endmodule

// File: rtl/svc_mbox_ctrl.sv
module svc_mbox_ctrl
    import svc_mbox_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              pend_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic [CMD_W-1:0]  done_status,
    output logic              busy,
    output svc_cmd_t          cmd,
    output logic              notify_q,
    output logic [7:0]        result,
    output logic [CMD_W-1:0]  status_code,
    output logic              pend
);

    ctrl_write_t cw;
    logic        try_req;
    logic        ofs_ok;
    logic        accept;
    logic        do_abort;
    logic        finish;
    logic        clr_pend;

    assign cw       = split_ctrl(wdata);
    assign ofs_ok   = ({1'b0, cw.cmd.offset} < (OFS_W+1)'(DEPTH));
    assign try_req  = ctrl_we && cw.req && !cw.abort;
    assign accept   = try_req && !busy && ofs_ok;
    assign do_abort = ctrl_we && cw.abort && busy;
    assign finish   = done && busy;
    assign clr_pend = pend_we && (wdata == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cmd      <= '0;
            notify_q <= 1'b0;
        end else if (accept) begin
            busy     <= 1'b1;
            cmd      <= cw.cmd;
            notify_q <= cw.notify;
        end else if (finish || do_abort) begin
            busy     <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= RES_OK;
        end else if (try_req) begin
            if (busy)        result <= RES_BUSY;
            else if (!ofs_ok) result <= RES_PARAM;
            else             result <= RES_OK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_code <= '0;
        end else if (finish) begin
            status_code <= done_status;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (finish && notify_q) begin
            pend <= 1'b1;
        end else if (clr_pend) begin
            pend <= 1'b0;
        end
    end

    // R3: an accepted request raises busy with the written command
    a_r3_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && wdata[BIT_REQ] && !wdata[BIT_ABORT] && !busy && ofs_ok)
        |=> busy && cmd == $past(wdata[FIELD_LSB +: CMD_W]));

    // R4: request while busy keeps the command
    a_r4_busy_keeps_cmd: assert property (@(posedge clk) disable iff (rst)
        (busy && ctrl_we && wdata[BIT_REQ]) |=> $stable(cmd) && result != RES_OK);

    // R6: completion drops busy and latches the status
    a_r6_done_clears: assert property (@(posedge clk) disable iff (rst)
        (busy && done) |=> !busy && status_code == $past(done_status));

    // R7: notify completion raises the pending bit
    a_r7_notify_irq: assert property (@(posedge clk) disable iff (rst)
        (busy && done && notify_q) |=> pend);

    // R8: pending holds until a zero write
    a_r8_pend_holds: assert property (@(posedge clk) disable iff (rst)
        (pend && !(pend_we && wdata == '0)) |=> pend);

    // R11: idle completion leaves the status code alone
    a_r11_idle_done: assert property (@(posedge clk) disable iff (rst)
        (!busy && done) |=> $stable(status_code));

    // R10: abort never raises the pending bit
    a_r10_abort_quiet: assert property (@(posedge clk) disable iff (rst)
        (busy && ctrl_we && wdata[BIT_ABORT] && !done && !pend) |=> !busy && !pend);

endmodule

// File: rtl/svc_mailbox.sv
module svc_mailbox
    import svc_mbox_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [11:0]       bus_addr,
    input  logic              bus_wen,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              ctl_req,
    output logic [15:0]       ctl_cmd,
    input  logic              ctl_done,
    input  logic [15:0]       ctl_status,
    input  logic              ctl_wen,
    input  logic [IDXW-1:0]   ctl_widx,
    input  logic [31:0]       ctl_wdata
);

    reg_sel_e          sel;
    logic [IDXW-1:0]   idx;
    logic              idx_ok;
    logic              busy;
    svc_cmd_t          cmd;
    logic              notify_q;
    logic [7:0]        result;
    logic [CMD_W-1:0]  status_code;
    logic              pend;
    logic [DATA_W-1:0] ram_rd;
    logic [3:0]        flags;

    svc_mbox_decode #(.DEPTH(DEPTH)) i_decode (
        .addr   (bus_addr),
        .sel    (sel),
        .idx    (idx),
        .idx_ok (idx_ok)
    );

    svc_mbox_ram #(.DEPTH(DEPTH)) i_ram (
        .clk     (clk),
        .rst     (rst),
        .h_we    (bus_wen && sel == SEL_MBOX && idx_ok),
        .h_be    (bus_be),
        .h_idx   (idx),
        .h_wdata (bus_wdata),
        .c_we    (ctl_wen),
        .c_idx   (ctl_widx),
        .c_wdata (ctl_wdata),
        .r_idx   (idx),
        .r_data  (ram_rd)
    );

    svc_mbox_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ctrl_we     (bus_wen && sel == SEL_CTRL),
        .pend_we     (bus_wen && sel == SEL_PEND),
        .wdata       (bus_wdata),
        .done        (ctl_done),
        .done_status (ctl_status),
        .busy        (busy),
        .cmd         (cmd),
        .notify_q    (notify_q),
        .result      (result),
        .status_code (status_code),
        .pend        (pend)
    );

    always_comb begin
        flags              = '0;
        flags[BIT_REQ]     = busy;
        flags[BIT_BUSY]    = busy;
        flags[BIT_NOTIFY]  = busy && notify_q;
    end

    always_comb begin
        case (sel)
            SEL_CTRL: bus_rdata = {cmd, 12'h000, flags};
            SEL_STAT: bus_rdata = {status_code, result, 4'h0, flags};
            SEL_PEND: bus_rdata = {31'h0, pend};
            SEL_MBOX: bus_rdata = idx_ok ? ram_rd : '0;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq     = pend;
    assign ctl_req = busy;
    assign ctl_cmd = cmd;

endmodule

// File: tb/test_svc_mailbox.sv
`timescale 1ns/1ps
module test_svc_mailbox;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        ctl_req;
    logic [15:0] ctl_cmd;
    logic        ctl_done = 1'b0;
    logic [15:0] ctl_status = '0;
    logic        ctl_wen = 1'b0;
    logic [5:0]  ctl_widx = '0;
    logic [31:0] ctl_wdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    svc_mailbox i_svc_mailbox (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .ctl_req(ctl_req), .ctl_cmd(ctl_cmd),
        .ctl_done(ctl_done), .ctl_status(ctl_status),
        .ctl_wen(ctl_wen), .ctl_widx(ctl_widx), .ctl_wdata(ctl_wdata)
    );

    localparam int NV = 6;
    localparam logic [5:0]  V_IDX  [NV] = '{6'd0, 6'd0, 6'd0, 6'd3, 6'd3, 6'd63};
    localparam logic [3:0]  V_BE   [NV] = '{4'hF, 4'h1, 4'h6, 4'h8, 4'h3, 4'hF};
    localparam logic [31:0] V_DATA [NV] = '{32'h11223344, 32'hAABBCCDD, 32'h55667788,
                                           32'h99000000, 32'h0000BEEF, 32'hCAFEF00D};
    localparam logic [31:0] V_EXP  [NV] = '{32'h11223344, 32'h112233DD, 32'h116677DD,
                                           32'h99000000, 32'h9900BEEF, 32'hCAFEF00D};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_done(input logic [15:0] st);
        @(negedge clk);
        ctl_done = 1'b1; ctl_status = st;
        @(negedge clk);
        ctl_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(12'h054, rd); check("R1 status", rd, 32'h0);
        bus_read(12'h050, rd); check("R1 control", rd, 32'h0);
        bus_read(12'h060, rd); check("R1 pending", rd, 32'h0);
        check("R1 irq/req", {30'h0, irq, ctl_req}, 32'h0);

        // R2 table of byte-strobed writes
        for (int i = 0; i < NV; i++) begin
            bus_write(12'h800 + {4'h0, V_IDX[i], 2'b00}, V_BE[i], V_DATA[i]);
            bus_read(12'h800 + {4'h0, V_IDX[i], 2'b00}, rd);
            check($sformatf("R2 vector %0d", i), rd, V_EXP[i]);
        end

        // R3 accept: offset 2, opcode 0x15, notify
        bus_write(12'h050, 4'hF, 32'h0115_0009);
        check("R3 ctl_req", {31'h0, ctl_req}, 32'h1);
        check("R3 ctl_cmd", {16'h0, ctl_cmd}, 32'h0115);
        bus_read(12'h054, rd); check("R3 status", rd, 32'h0000_000B);

        // R4 request while busy
        bus_write(12'h050, 4'hF, 32'h0222_0009);
        check("R4 ctl_cmd kept", {16'h0, ctl_cmd}, 32'h0115);
        bus_read(12'h054, rd); check("R4 result", rd, 32'h0000_EF0B);
        bus_read(12'h800, rd); check("R4 mailbox kept", rd, 32'h116677DD);

        // R9 controller writes a response word (echo)
        @(negedge clk);
        ctl_wen = 1'b1; ctl_widx = 6'd2; ctl_wdata = {16'hDEAD, ctl_cmd};
        @(negedge clk);
        ctl_wen = 1'b0;
        bus_read(12'h808, rd); check("R9 response word", rd, 32'hDEAD_0115);

        // R6 / R7 completion with notify
        pulse_done(16'h1234);
        check("R6 ctl_req low", {31'h0, ctl_req}, 32'h0);
        check("R7 irq set", {31'h0, irq}, 32'h1);
        bus_read(12'h054, rd); check("R6 status code", rd, 32'h1234_EF00);

        // R8 nonzero write ignored, zero clears
        bus_write(12'h060, 4'hF, 32'h1);
        check("R8 nonzero ignored", {31'h0, irq}, 32'h1);
        bus_write(12'h060, 4'hF, 32'h0);
        check("R8 zero clears", {31'h0, irq}, 32'h0);

        // R7 completion without notify
        bus_write(12'h050, 4'hF, 32'h0115_0001);
        pulse_done(16'h0042);
        check("R7 no notify no irq", {31'h0, irq}, 32'h0);
        bus_read(12'h054, rd); check("R7 status", rd, 32'h0042_0000);

        // R5 offset 64 out of range
        bus_write(12'h050, 4'hF, 32'h2001_0009);
        check("R5 not started", {31'h0, ctl_req}, 32'h0);
        bus_read(12'h054, rd); check("R5 result", rd, 32'h0042_FF00);

        // R11 idle done
        pulse_done(16'h7777);
        bus_read(12'h054, rd); check("R11 idle done", rd, 32'h0042_FF00);

        // R10 abort
        bus_write(12'h050, 4'hF, 32'h0115_0009);
        bus_write(12'h050, 4'hF, 32'h0000_0004);
        check("R10 abort req", {31'h0, ctl_req}, 32'h0);
        check("R10 abort irq", {31'h0, irq}, 32'h0);
        bus_read(12'h054, rd); check("R10 abort status", rd, 32'h0042_0000);
        bus_write(12'h050, 4'hF, 32'h0115_0005);
        check("R10 abort never starts", {31'h0, ctl_req}, 32'h0);

        // R8 completion and clear in the same cycle
        bus_write(12'h050, 4'hF, 32'h0115_0009);
        @(negedge clk);
        ctl_done = 1'b1; ctl_status = 16'h0055;
        bus_addr = 12'h060; bus_wdata = 32'h0; bus_be = 4'hF; bus_wen = 1'b1;
        @(negedge clk);
        ctl_done = 1'b0; bus_wen = 1'b0;
        check("R8 set beats clear", {31'h0, irq}, 32'h1);
        bus_read(12'h054, rd); check("R6 status 0055", rd, 32'h0055_0000);
        bus_write(12'h060, 4'hF, 32'h0);

        // R4 completion and new request in the same cycle
        bus_write(12'h050, 4'hF, 32'h0115_0009);
        @(negedge clk);
        ctl_done = 1'b1; ctl_status = 16'h0066;
        bus_addr = 12'h050; bus_wdata = 32'h0080_0009; bus_be = 4'hF; bus_wen = 1'b1;
        @(negedge clk);
        ctl_done = 1'b0; bus_wen = 1'b0;
        check("R4 same-cycle req refused", {31'h0, ctl_req}, 32'h0);
        bus_read(12'h054, rd); check("R4 same-cycle result", rd, 32'h0066_EF00);

        finish_run();
    end

endmodule